// File: doc/BRIEF.md
# Multispectral Pixel Cloud Pre-Classifier

This block labels each pixel of a multispectral image stream as cloud, clear (non-cloud) or ambiguous, as the first screening step of on-board cloud detection. Every pixel brings five co-registered 8-bit samples: green and red (visible), near-IR, mid-IR and thermal. Six tests run on each pixel. Two are plain threshold tests: one checks that the pixel is bright, the other that it is cold. Four are band-ratio tests, and each is worked out as a multiply followed by a compare, with no divider. A pixel that fails the bright test or the cold test is clear. A pixel that passes all six is cloud. Any other pixel is ambiguous and is left for a later stage to resolve.

The pipeline takes one pixel per clock and never stalls. The label leaves on a valid/class stream a fixed three cycles later. Before a scene starts, six 16-bit coefficients with 8 fractional bits are written through a simple write port. Clouds tend to be bright and cold, and the coefficients set how strict each test is.

Top module: `cc_pixel_classifier`

## Requirements
- R1: A new pixel is accepted on every cycle that `in_valid` is high, with no stall. Each accepted pixel yields exactly one output beat, and outputs keep input order.
- R2: `out_valid` for a pixel rises exactly three clock edges after the edge that samples its `in_valid`.
- R3: `out_class` uses 2'b00 for clear, 2'b01 for cloud and 2'b10 for ambiguous. 2'b11 never appears while `out_valid` is high.
- R4: A pixel that fails the bright test (index 0) or the cold test (index 1) is labelled clear, whatever the other tests give.
- R5: A pixel that passes all six tests is labelled cloud.
- R6: A pixel that passes tests 0 and 1 but fails any of tests 2 to 5 is labelled ambiguous.
- R7: Each test compares sample·256 against C·x, where C is the 16-bit coefficient and the comparison is strict, so equality fails. Index 0 passes if red·256 > C0. Index 1 passes if thermal·256 < C1. Index 2 passes if green·256 < C2·midIR. Index 3 passes if nearIR·256 < C3·red. Index 4 passes if nearIR·256 < C4·green. Index 5 passes if nearIR·256 > C5·midIR.
- R8: A write with `cfg_we` high and `cfg_sel` = i (0 to 5) loads `cfg_data` into coefficient Ci at that clock edge. A pixel sampled at the same edge still uses the old value. Pixels sampled at later edges use the new one.
- R9: Writes with `cfg_sel` equal to 6 or 7 are ignored and leave all six coefficients unchanged.
- R10: `rst_n` low asynchronously clears the pipeline valid bits, sets `out_class` to 2'b00 and clears all coefficients to zero. Pixels in flight when reset arrives produce no output.
- R11: While `out_valid` is low, `out_class` holds the last label delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Coefficient index (0 to 5 valid) |
| cfg_data | input | 16 | Coefficient value, 8 fractional bits |
| in_valid | input | 1 | Pixel valid |
| in_green | input | 8 | Green sample |
| in_red | input | 8 | Red sample |
| in_nir | input | 8 | Near-IR sample |
| in_mir | input | 8 | Mid-IR sample |
| in_therm | input | 8 | Thermal sample |
| out_valid | output | 1 | Label valid |
| out_class | output | 2 | Label: 00 clear, 01 cloud, 10 ambiguous |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 8 fractional bits and 16-bit coefficients. With these widths, every test boundary falls on a whole sample value, so pixels can be chosen that land exactly on equality in both a threshold test and a ratio test, and the strict compare can be checked there. The 3-bit select leaves two unused codes, and the bench writes to both of them. Random back-to-back streams and streams with bubbles are checked against a reference model that runs on the bench's own copy of the coefficients.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Number of screening tests; index order defines coefficient select codes.
  localparam int N_TESTS = 6;
  localparam int SEL_W   = $clog2(N_TESTS);

  localparam int T_BRIGHT = 0;
  localparam int T_COLD   = 1;
  localparam int T_SNOW   = 2;
  localparam int T_VEG    = 3;
  localparam int T_SENES  = 4;
  localparam int T_SOIL   = 5;

  // Bit i set: test i passes when lhs is strictly greater; clear: strictly less.
  localparam logic [N_TESTS-1:0] GT_MASK = 6'b100001;

  // Pipeline depth from input sample to output label.
  localparam int LATENCY = 3;

  typedef enum logic [1:0] {
    CLS_CLEAR = 2'b00,
    CLS_CLOUD = 2'b01,
    CLS_AMBIG = 2'b10
  } cls_e;
endpackage

// File: rtl/cc_coef_regs.sv
module cc_coef_regs #(
  parameter int COEF_W  = 16,
  parameter int N_COEF  = cc_pkg::N_TESTS,
  parameter int SEL_W   = cc_pkg::SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [COEF_W-1:0]        cfg_data,
  output logic [N_COEF*COEF_W-1:0] coef_flat
);
  for (genvar gi = 0; gi < N_COEF; gi++) begin : g_coef
    logic              wr_en;
    logic [COEF_W-1:0] coef_d;
    logic [COEF_W-1:0] coef_q;

    always_comb begin
      wr_en  = cfg_we && (cfg_sel == SEL_W'(gi));
      coef_d = cfg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coef_q <= '0;
      end else if (wr_en) begin
        coef_q <= coef_d;
      end
    end

    assign coef_flat[gi*COEF_W +: COEF_W] = coef_q;
  end
endmodule

// File: rtl/cc_test_lane.sv
module cc_test_lane #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 8,
  parameter int COEF_W   = 16,
  parameter bit GREATER  = 1'b1
) (
  input  logic                clk,
  input  logic                en_a,
  input  logic                en_b,
  input  logic [SAMPLE_W-1:0] lhs,
  input  logic [SAMPLE_W-1:0] rhs,
  input  logic [COEF_W-1:0]   coef,
  output logic                pass
);
  localparam int LHS_W  = SAMPLE_W + FRAC_W;
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int CMP_W  = (LHS_W > PROD_W) ? LHS_W : PROD_W;

  logic [LHS_W-1:0]  lhs_scaled;
  logic [PROD_W-1:0] prod_full;
  logic [CMP_W-1:0]  lhs_d, lhs_q;
  logic [CMP_W-1:0]  prod_d, prod_q;
  logic              pass_d, pass_q;

  // Stage A next state: scaled sample and coefficient product.
  always_comb begin
    lhs_scaled = {lhs, {FRAC_W{1'b0}}};
    prod_full  = PROD_W'(coef) * PROD_W'(rhs);
    lhs_d      = CMP_W'(lhs_scaled);
    prod_d     = CMP_W'(prod_full);
  end

  // Stage B next state: strict comparison in the chosen direction.
  if (GREATER) begin : g_gt
    always_comb pass_d = (lhs_q > prod_q);
  end else begin : g_lt
    always_comb pass_d = (lhs_q < prod_q);
  end

  always_ff @(posedge clk) begin
    if (en_a) begin
      lhs_q  <= lhs_d;
      prod_q <= prod_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en_b) begin
      pass_q <= pass_d;
    end
  end

  assign pass = pass_q;
endmodule

// File: rtl/cc_label_stage.sv
module cc_label_stage #(
  parameter int N_TESTS = cc_pkg::N_TESTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [N_TESTS-1:0] pass,
  output logic [1:0]         label
);
  import cc_pkg::*;

  cls_e label_d, label_q;

  always_comb begin
    if (!pass[T_BRIGHT] || !pass[T_COLD]) begin
      label_d = CLS_CLEAR;
    end else if (&pass) begin
      label_d = CLS_CLOUD;
    end else begin
      label_d = CLS_AMBIG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      label_q <= CLS_CLEAR;
    end else if (en) begin
      label_q <= label_d;
    end
  end

  assign label = label_q;
endmodule

// File: rtl/cc_pixel_classifier.sv
module cc_pixel_classifier #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 8,
  parameter int COEF_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [cc_pkg::SEL_W-1:0] cfg_sel,
  input  logic [COEF_W-1:0]        cfg_data,
  input  logic                     in_valid,
  input  logic [SAMPLE_W-1:0]      in_green,
  input  logic [SAMPLE_W-1:0]      in_red,
  input  logic [SAMPLE_W-1:0]      in_nir,
  input  logic [SAMPLE_W-1:0]      in_mir,
  input  logic [SAMPLE_W-1:0]      in_therm,
  output logic                     out_valid,
  output logic [1:0]               out_class
);
  import cc_pkg::*;

  localparam int NT = N_TESTS;

  logic [NT*COEF_W-1:0] coef_flat;
  logic [SAMPLE_W-1:0]  lane_lhs [NT];
  logic [SAMPLE_W-1:0]  lane_rhs [NT];
  logic [NT-1:0]        lane_pass;

  logic [LATENCY-1:0]   vld_d, vld_q;

  cc_coef_regs #(
    .COEF_W (COEF_W),
    .N_COEF (NT),
    .SEL_W  (SEL_W)
  ) u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .coef_flat (coef_flat)
  );

  // Band routing; threshold tests use a unit right-hand operand.
  always_comb begin
    lane_lhs[T_BRIGHT] = in_red;
    lane_rhs[T_BRIGHT] = SAMPLE_W'(1);
    lane_lhs[T_COLD]   = in_therm;
    lane_rhs[T_COLD]   = SAMPLE_W'(1);
    lane_lhs[T_SNOW]   = in_green;
    lane_rhs[T_SNOW]   = in_mir;
    lane_lhs[T_VEG]    = in_nir;
    lane_rhs[T_VEG]    = in_red;
    lane_lhs[T_SENES]  = in_nir;
    lane_rhs[T_SENES]  = in_green;
    lane_lhs[T_SOIL]   = in_nir;
    lane_rhs[T_SOIL]   = in_mir;
  end

  // Valid shift register, one bit per pipeline stage.
  always_comb begin
    vld_d = {vld_q[LATENCY-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  for (genvar gt = 0; gt < NT; gt++) begin : g_lane
    cc_test_lane #(
      .SAMPLE_W (SAMPLE_W),
      .FRAC_W   (FRAC_W),
      .COEF_W   (COEF_W),
      .GREATER  (GT_MASK[gt])
    ) u_lane (
      .clk  (clk),
      .en_a (in_valid),
      .en_b (vld_q[0]),
      .lhs  (lane_lhs[gt]),
      .rhs  (lane_rhs[gt]),
      .coef (coef_flat[gt*COEF_W +: COEF_W]),
      .pass (lane_pass[gt])
    );
  end

  cc_label_stage #(
    .N_TESTS (NT)
  ) u_label (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (vld_q[1]),
    .pass  (lane_pass),
    .label (out_class)
  );

  assign out_valid = vld_q[LATENCY-1];
endmodule

// File: rtl/cc_pixel_classifier_chk.sv
module cc_pixel_classifier_chk #(
  parameter int COEF_W  = 16,
  parameter int N_TESTS = cc_pkg::N_TESTS,
  parameter int SEL_W   = cc_pkg::SEL_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [SEL_W-1:0]          cfg_sel,
  input logic [COEF_W-1:0]         cfg_data,
  input logic [N_TESTS*COEF_W-1:0] coef_flat,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic [1:0]                out_class
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));  // R2

  AST_NO_CODE_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class != 2'b11));  // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst != 2'd0) && !out_valid) |-> $stable(out_class));  // R11

  AST_SEL_UNUSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel >= SEL_W'(N_TESTS))) |=> $stable(coef_flat));  // R9

  AST_COEF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel < SEL_W'(N_TESTS))) |=>
      (coef_flat[$past(cfg_sel)*COEF_W +: COEF_W] == $past(cfg_data)));  // R8

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!out_valid && (out_class == 2'b00));  // R10
    end
  end
endmodule

bind cc_pixel_classifier cc_pixel_classifier_chk #(
  .COEF_W  (COEF_W),
  .N_TESTS (cc_pkg::N_TESTS),
  .SEL_W   (cc_pkg::SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_data  (cfg_data),
  .coef_flat (coef_flat),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_class (out_class)
);

// File: tb/cc_pixel_classifier_bench.sv
module cc_pixel_classifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_data = 16'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_green = 8'd0, in_red = 8'd0, in_nir = 8'd0, in_mir = 8'd0, in_therm = 8'd0;
  logic        out_valid;
  logic [1:0]  out_class;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  int    bench_coef [6];
  logic [1:0] exp_cls [2048];
  int    exp_at  [2048];
  string exp_req [2048];
  int    wr_idx = 0;
  int    rd_idx = 0;
  logic [1:0] last_cls = 2'b00;
  logic [31:0] rng = 32'h1234_5678;

  cc_pixel_classifier u_cc_pixel_classifier (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .in_valid  (in_valid),
    .in_green  (in_green),
    .in_red    (in_red),
    .in_nir    (in_nir),
    .in_mir    (in_mir),
    .in_therm  (in_therm),
    .out_valid (out_valid),
    .out_class (out_class)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Reference model from R4..R7.
  function automatic logic [1:0] model(int g, int r, int n, int m, int t);
    bit p0, p1, p2, p3, p4, p5;
    p0 = (r * 256) > bench_coef[0];
    p1 = (t * 256) < bench_coef[1];
    p2 = (g * 256) < bench_coef[2] * m;
    p3 = (n * 256) < bench_coef[3] * r;
    p4 = (n * 256) < bench_coef[4] * g;
    p5 = (n * 256) > bench_coef[5] * m;
    if (!p0 || !p1) return 2'b00;
    if (p2 && p3 && p4 && p5) return 2'b01;
    return 2'b10;
  endfunction

  // Output monitor: order, label and latency of every beat (R1, R2).
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd_idx >= wr_idx) begin
        check(1'b0, "R1 unexpected output", 1, 0);
      end else begin
        check(out_class == exp_cls[rd_idx], exp_req[rd_idx], out_class, exp_cls[rd_idx]);
        check(cyc == exp_at[rd_idx], "R2 latency", cyc, exp_at[rd_idx]);
        rd_idx++;
      end
      last_cls = out_class;
    end
  end

  task automatic drive_now(input int g, input int r, input int n, input int m, input int t,
                           input logic [1:0] e, input string req);
    in_valid = 1'b1;
    in_green = 8'(g); in_red = 8'(r); in_nir = 8'(n); in_mir = 8'(m); in_therm = 8'(t);
    exp_cls[wr_idx] = e;
    exp_at[wr_idx]  = cyc + 3;
    exp_req[wr_idx] = req;
    wr_idx++;
  endtask

  task automatic push_pixel(input int g, input int r, input int n, input int m, input int t,
                            input logic [1:0] e, input string req);
    @(negedge clk);
    drive_now(g, r, n, m, t, e, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic load_coef(input int sel, input int val);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = 16'(val);
    if (sel < 6) bench_coef[sel] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_standard();
    load_coef(0, 16'h3200);  // red > 50
    load_coef(1, 16'h9600);  // thermal < 150
    load_coef(2, 16'h0180);  // green < 1.5 midIR
    load_coef(3, 16'h0200);  // nearIR < 2 red
    load_coef(4, 16'h0280);  // nearIR < 2.5 green
    load_coef(5, 16'h0080);  // nearIR > 0.5 midIR
  endtask

  task automatic drain(input string req);
    idle(6);
    check(rd_idx == wr_idx, req, rd_idx, wr_idx);
    rd_idx = wr_idx;
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid low in reset", out_valid, 0);
    check(out_class == 2'b00, "R10 class clear in reset", out_class, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) bench_coef[i] = 0;
    idle(2);
    check(out_valid == 1'b0, "R10 idle after release", out_valid, 0);
  endtask

  task automatic t_classes();
    load_standard();
    push_pixel(40, 100, 60, 30, 100, 2'b01, "R5 all tests pass");
    push_pixel(40, 30, 60, 30, 100, 2'b00, "R4 dim red");
    push_pixel(40, 100, 60, 30, 200, 2'b00, "R4 warm thermal");
    push_pixel(200, 100, 60, 10, 100, 2'b10, "R6 snow ratio fails");
    push_pixel(40, 100, 10, 100, 100, 2'b10, "R6 soil ratio fails");
    push_pixel(40, 100, 250, 30, 100, 2'b10, "R6 vegetation ratio fails");
    push_pixel(200, 10, 10, 10, 250, 2'b00, "R4 both gates fail, ratios odd");
    drain("R1 one output per pixel (classes)");
  endtask

  task automatic t_boundaries();
    push_pixel(40, 50, 60, 30, 100, 2'b00, "R7 bright equality fails");
    push_pixel(40, 100, 60, 30, 150, 2'b00, "R7 cold equality fails");
    push_pixel(40, 51, 60, 30, 149, 2'b01, "R7 just inside both gates");
    push_pixel(60, 100, 60, 40, 100, 2'b10, "R7 snow ratio equality fails");
    push_pixel(40, 100, 60, 120, 100, 2'b10, "R7 soil ratio equality fails");
    push_pixel(40, 100, 60, 119, 100, 2'b01, "R7 soil ratio just passes");
    drain("R1 one output per pixel (boundaries)");
  endtask

  task automatic t_stream(input int n, input bit bubbles);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a, b;
      int g, r, nn, m, t;
      a = rnd(); b = rnd();
      g = int'(a[7:0]); r = int'(a[15:8]); nn = int'(a[23:16]);
      m = int'(a[31:24]); t = int'(b[7:0]);
      if (bubbles && b[9:8] == 2'b00) idle(1 + int'(b[11:10]));
      push_pixel(g, r, nn, m, t, model(g, r, nn, m, t),
                 bubbles ? "R1 stream with bubbles" : "R1 back-to-back stream");
    end
    drain("R1 stream output count");
  endtask

  task automatic t_hold();
    push_pixel(40, 100, 60, 30, 100, 2'b01, "R5 before hold");
    push_pixel(200, 100, 60, 10, 100, 2'b10, "R6 before hold");
    idle(6);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R11 idle valid", out_valid, 0);
      check(out_class == 2'b10, "R11 label held", out_class, 2);
    end
    rd_idx = wr_idx;
  endtask

  task automatic t_ignored_sel();
    load_coef(6, 16'h0000);
    load_coef(7, 16'h0000);
    push_pixel(40, 100, 60, 30, 100, 2'b01, "R9 unused select ignored");
    push_pixel(40, 100, 60, 30, 149, 2'b01, "R9 cold coefficient intact");
    drain("R9 outputs present");
  endtask

  task automatic t_coef_timing();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_data = 16'h3200;
    drive_now(40, 100, 60, 30, 100, 2'b01, "R8 same-edge pixel uses old coefficient");
    bench_coef[1] = 16'h3200;
    @(negedge clk);
    cfg_we = 1'b0;
    drive_now(40, 100, 60, 30, 100, 2'b00, "R8 next pixel uses new coefficient");
    drain("R8 outputs present");
    load_coef(1, 16'h9600);
  endtask

  task automatic t_reset_mid();
    push_pixel(40, 100, 60, 30, 100, 2'b01, "R10 in flight");
    push_pixel(40, 100, 60, 30, 100, 2'b01, "R10 in flight");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    rd_idx = wr_idx;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10 in-flight pixels dropped", out_valid, 0);
    end
    check(out_class == 2'b00, "R10 class cleared", out_class, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) bench_coef[i] = 0;
    push_pixel(40, 100, 60, 30, 100, 2'b00, "R10 coefficients cleared");
    drain("R10 output after reset");
  endtask

  initial begin
    t_reset_state();
    t_classes();
    t_boundaries();
    t_stream(300, 1'b0);
    t_stream(200, 1'b1);
    t_hold();
    t_ignored_sel();
    t_coef_timing();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule